// File: doc/BRIEF.md
# Start/Stop/Step Hexadecimal Counter Controller

This block turns four push-button inputs into control of a 4-bit hexadecimal counter. A start button makes the counter run, a stop button halts it, a step button adds one to the count, and a clear button sends the count back to zero. While the block is running, the count advances once for every tick of an internal divider. The divider length is a parameter, so one tick can be one second at the system clock rate or a few cycles in simulation.

Each button first passes through a two-flop synchronizer and then an edge detector. Only the press counts, so holding a button down does nothing more. Start and stop set and clear a registered run flag. Step and clear become registered pulses one clock wide. The counter combines the step pulse with the timed enable, lets clear override both, and gives a registered flag while the count sits at its maximum value. Display decoding is not part of this block.

Top module: `hex_step_counter`

## Requirements
- R1: While reset is high and in the first cycle after it, `count` is 0, `running` is 0 and `term_cnt` is 0.
- R2: A button input that goes high before clock edge k changes `running` at edge k+2 and `count` at edge k+3.
- R3: A rising edge on `btn_start` sets `running` to 1, and it stays 1 after the button is released.
- R4: A rising edge on `btn_stop` clears `running` to 0. When start and stop edges arrive in the same cycle, `running` ends up 0.
- R5: A rising edge on `btn_step` adds exactly one to `count`. Holding the button for many cycles still adds only one.
- R6: A rising edge on `btn_clear` sets `count` to 0. This wins over a step pulse and over a timed increment in the same cycle.
- R7: While `running` is 1, `count` goes up by one every TICK_DIV cycles. The phase of this comes from the last clear: if the clear takes effect at edge E, the increments come at edges E+TICK_DIV, E+2*TICK_DIV, and so on.
- R8: The count wraps from 15 (hex F) to 0. `term_cnt` is 1 exactly while `count` equals 15.
- R9: A step pulse that lands in the same cycle as a timed increment gives a single increment, not two.
- R10: While `running` is 0 and no button is pressed, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_start | input | 1 | Start button, raw level |
| btn_stop | input | 1 | Stop button, raw level |
| btn_step | input | 1 | Single-step button, raw level |
| btn_clear | input | 1 | Clear button, raw level |
| count | output | CNT_W | Current counter value |
| term_cnt | output | 1 | High while the count is at its maximum |
| running | output | 1 | Run flag |

## Verification
Two pairs of functions can land on the same clock edge: the timed increment and a step pulse, and clear and step. The bench uses a clear to fix the tick phase, so it knows exactly which edges carry timed increments. It then raises the step button four cycles before one of those edges and checks that the count goes up by one, not two. A step placed off the tick grid serves as the control and must add one. Clear and step are pressed together and the count must end at zero. Start and stop are also pressed together, and the run flag must end up cleared.

// File: rtl/hsc_pkg.sv
`timescale 1ns/1ps
package hsc_pkg;
  localparam int NUM_BTN = 4;

  // Bit positions of the buttons inside the packed button vector
  localparam int BTN_START = 0;
  localparam int BTN_STOP  = 1;
  localparam int BTN_STEP  = 2;
  localparam int BTN_CLEAR = 3;

  // Registered outputs of the controller
  typedef struct packed {
    logic run;
    logic step;
    logic clear;
  } ctrl_t;
endpackage

// File: rtl/hsc_btn_edge.sv
`timescale 1ns/1ps
// Synchronizes one raw button level and flags its rising edge for one cycle.
module hsc_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic rise_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], btn_i};
      prev_q <= sync_q[MSB];
    end
  end

  assign rise_o = sync_q[MSB] & ~prev_q;
endmodule

// File: rtl/hsc_ctrl.sv
`timescale 1ns/1ps
// Turns button edges into a set/reset run flag and one-cycle step/clear pulses.
module hsc_ctrl
  import hsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] rise_i,
  output ctrl_t              ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      // stop takes precedence over start
      if (rise_i[BTN_STOP])
        ctrl_q.run <= 1'b0;
      else if (rise_i[BTN_START])
        ctrl_q.run <= 1'b1;
      ctrl_q.step  <= rise_i[BTN_STEP];
      ctrl_q.clear <= rise_i[BTN_CLEAR];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/hsc_tick.sv
`timescale 1ns/1ps
// Divide-by-DIV tick: one-cycle enable every DIV cycles, phase restarted by restart_i.
module hsc_tick #(
  parameter int DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i)
      cnt_q <= '0;
    else if (cnt_q == LAST)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/hsc_hex_count.sv
`timescale 1ns/1ps
// Wrapping counter with clear priority and a registered terminal-count flag.
module hsc_hex_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         tick_i,
  input  logic         run_i,
  output logic [W-1:0] count_o,
  output logic         term_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         term_q;
  logic         advance;

  // step and timed tick merge into a single increment
  assign advance = step_i | (tick_i & run_i);

  always_comb begin
    if (clear_i)
      cnt_nxt = '0;
    else if (advance)
      cnt_nxt = cnt_q + W'(1);
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      term_q <= (cnt_nxt == '1);
    end
  end

  assign count_o = cnt_q;
  assign term_o  = term_q;
endmodule

// File: rtl/hex_step_counter.sv
`timescale 1ns/1ps
module hex_step_counter
  import hsc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int TICK_DIV    = 100_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_start,
  input  logic             btn_stop,
  input  logic             btn_step,
  input  logic             btn_clear,
  output logic [CNT_W-1:0] count,
  output logic             term_cnt,
  output logic             running
);
  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] btn_rise;
  ctrl_t              ctrl;
  logic               tick;

  assign btn_raw[BTN_START] = btn_start;
  assign btn_raw[BTN_STOP]  = btn_stop;
  assign btn_raw[BTN_STEP]  = btn_step;
  assign btn_raw[BTN_CLEAR] = btn_clear;

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    hsc_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .btn_i  (btn_raw[i]),
      .rise_o (btn_rise[i])
    );
  end

  hsc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .rise_i (btn_rise),
    .ctrl_o (ctrl)
  );

  hsc_tick #(.DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .restart_i (ctrl.clear),
    .tick_o    (tick)
  );

  hsc_hex_count #(.W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .clear_i (ctrl.clear),
    .step_i  (ctrl.step),
    .tick_i  (tick),
    .run_i   (ctrl.run),
    .count_o (count),
    .term_o  (term_cnt)
  );

  assign running = ctrl.run;
endmodule

// File: rtl/hsc_checker.sv
`timescale 1ns/1ps
module hsc_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] count,
  input logic         term_cnt,
  input logic         running,
  input logic         start_rise,
  input logic         stop_rise,
  input logic         step_pls,
  input logic         clr_pls
);
  assert_run_set_by_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(start_rise && !stop_rise));

  assert_run_clr_by_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(stop_rise));

  assert_step_adds_one_R5: assert property (@(posedge clk) disable iff (rst)
    (step_pls && !clr_pls) |=> (count == W'($past(count) + W'(1))));

  assert_step_single_R5: assert property (@(posedge clk) disable iff (rst)
    step_pls |=> !step_pls);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    clr_pls |=> (count == '0));

  assert_term_match_R8: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (count == '1));

  assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (rst)
    (!running && !step_pls && !clr_pls) |=> $stable(count));

  assert_count_moves_R7: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> ((count == W'($past(count) + W'(1))) || (count == '0)));
endmodule

bind hex_step_counter hsc_checker #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .count      (count),
  .term_cnt   (term_cnt),
  .running    (running),
  .start_rise (btn_rise[0]),
  .stop_rise  (btn_rise[1]),
  .step_pls   (ctrl.step),
  .clr_pls    (ctrl.clear)
);

// File: tb/tb_hex_step_counter.sv
`timescale 1ns/1ps
module tb_hex_step_counter;
  localparam int W = 4;
  localparam int N = 5;
  localparam int MOD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_start = 1'b0, b_stop = 1'b0, b_step = 1'b0, b_clear = 1'b0;
  logic [W-1:0] count;
  logic term_cnt, running;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hex_step_counter #(.CNT_W(W), .TICK_DIV(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst),
    .btn_start(b_start), .btn_stop(b_stop), .btn_step(b_step), .btn_clear(b_clear),
    .count(count), .term_cnt(term_cnt), .running(running)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // bit 0 start, 1 stop, 2 step, 3 clear
  task automatic set_btns(input logic [3:0] m);
    b_start = m[0]; b_stop = m[1]; b_step = m[2]; b_clear = m[3];
  endtask

  // Raises the buttons at the current negedge; eff is the edge at which count reacts
  task automatic press(input logic [3:0] m, input int hold, output int eff);
    @(negedge clk);
    set_btns(m);
    eff = cyc + 4;
    repeat (hold) @(negedge clk);
    set_btns(4'b0000);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int eff, base, c0, e_clr;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 0);
    chk("R1 running in reset", running, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count after reset", count, 0);
    chk("R1 running after reset", running, 0);
    chk("R1 term after reset", term_cnt, 0);

    // Step sweep across wrap while stopped
    for (int i = 1; i <= 18; i++) begin
      press(4'b0100, 2, eff);
      wait_until(eff - 1);
      chk("R2 step latency", count, (i - 1) % MOD);
      wait_until(eff);
      chk("R5 step count", count, i % MOD);
      chk("R8 term flag", term_cnt, (i % MOD) == 15 ? 1 : 0);
      repeat (2) @(negedge clk);
    end

    // Held step adds only one
    base = count;
    press(4'b0100, 30, eff);
    chk("R5 held step", count, (base + 1) % MOD);
    repeat (10) @(negedge clk);
    chk("R5 held step later", count, (base + 1) % MOD);
    repeat (4) @(negedge clk);

    // Stopped: count holds over several tick periods
    base = count;
    repeat (4 * N) @(negedge clk);
    chk("R10 hold while stopped", count, base);

    // Clear
    press(4'b1000, 2, eff);
    wait_until(eff - 1);
    chk("R2 clear latency", count, base);
    wait_until(eff);
    chk("R6 clear", count, 0);
    repeat (3) @(negedge clk);

    // Clear and step together
    press(4'b0100, 2, eff);
    wait_until(eff + 2);
    press(4'b1100, 2, eff);
    wait_until(eff);
    chk("R6 clear beats step", count, 0);
    repeat (3) @(negedge clk);

    // Start
    @(negedge clk);
    c0 = cyc;
    set_btns(4'b0001);
    wait_until(c0 + 2);
    chk("R2 run latency", running, 0);
    wait_until(c0 + 3);
    chk("R3 start sets run", running, 1);
    set_btns(4'b0000);
    repeat (6) @(negedge clk);
    chk("R3 run stays after release", running, 1);

    // Timed counting phased from clear, beyond a wrap
    press(4'b1000, 2, e_clr);
    wait_until(e_clr);
    for (int c = e_clr; c <= e_clr + N * 20; c++) begin
      wait_until(c);
      chk("R7 timed count", count, ((c - e_clr) / N) % MOD);
      chk("R8 term while running", term_cnt, (((c - e_clr) / N) % MOD) == 15 ? 1 : 0);
    end

    // Clear coinciding with a timed increment
    @(negedge clk);
    begin
      int last_inc;
      last_inc = e_clr + N * ((cyc - e_clr) / N + 3);
      wait_until(last_inc - 4);
      set_btns(4'b1000);
      wait_until(last_inc - 2);
      set_btns(4'b0000);
      wait_until(last_inc);
      chk("R6 clear beats tick", count, 0);
      e_clr = last_inc;
    end

    // Step coinciding with a tick, then a step off the tick grid
    begin
      int s_hit, s_off;
      s_hit = e_clr + 3 * N;
      s_off = e_clr + 6 * N + 2;
      for (int c = cyc; c <= e_clr + 9 * N; c++) begin
        wait_until(c);
        if (c == s_hit - 4 || c == s_off - 4) set_btns(4'b0100);
        if (c == s_hit - 2 || c == s_off - 2) set_btns(4'b0000);
        if (c >= e_clr)
          chk(c >= s_off ? "R9 control step" : "R9 step on tick",
              count, (((c - e_clr) / N) + (c >= s_off ? 1 : 0)) % MOD);
      end
    end

    // Stop
    @(negedge clk);
    c0 = cyc;
    set_btns(4'b0010);
    wait_until(c0 + 3);
    set_btns(4'b0000);
    chk("R4 stop clears run", running, 0);
    base = count;
    repeat (3 * N) @(negedge clk);
    chk("R10 hold after stop", count, base);

    // Start and stop together while running: stop wins
    press(4'b0001, 2, eff);
    wait_until(eff);
    chk("R3 restart", running, 1);
    repeat (2) @(negedge clk);
    press(4'b0011, 2, eff);
    wait_until(eff - 1);
    chk("R4 start+stop together", running, 0);
    repeat (8) @(negedge clk);
    chk("R4 run stays cleared", running, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule